// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Stage with Status Recording

This block is the integer add and subtract stage of a load-store CPU datapath. Each accepted operation forms one 32-bit sum, `first + second + carry`. The first operand is the register value, its complement, or a literal zero. The second operand is the other register, the sign-extended 16-bit immediate (used as is or moved up by 16 bits), zero, or all ones. The carry input is 0, 1, or the stored carry bit. The stage then works out which status updates the operation asks for: carry, overflow with its sticky summary bit, and a 4-bit condition field.

The decoder supplies an operation code, both register values, a flag that says the first register field was zero, the 16-bit immediate, the current carry and summary-overflow bits, and the overflow-enable and record bits. Bit 10 and bit 0 of the instruction word carry these two bits on register forms. One cycle after an accepted operation, the stage returns the sum, the new status values, and a write enable for each status target. A register file or status register outside the block applies the writes.

Top module: `fxadd_unit`

## Requirements
- R1: Every result and status value appears one clock after the cycle in which `in_valid` is high, and `out_valid` is high in that cycle. In any cycle where `out_valid` is low, `ca_we`, `ov_we` and `cr_we` are all low. After reset, every output is zero.
- R2: Immediate add (code 0) gives `(ra_is_zero ? 0 : ra_val) + sext(imm_val)`. Add-immediate-carrying (code 2) and its recording variant (code 3) always use `ra_val` plus the sign-extended immediate, whatever `ra_is_zero` is.
- R3: Shifted-immediate add (code 1) gives `(ra_is_zero ? 0 : ra_val) + (sext(imm_val) << 16)`.
- R4: Plain register add (code 5) gives `ra_val + rb_val`. Subtract-from (code 6) gives `~ra_val + rb_val + 1`. Carrying add (code 7) and carrying subtract-from (code 8) give the same two sums. Subtract-from-immediate (code 4) gives `~ra_val + sext(imm_val) + 1`.
- R5: Each extended form adds `ca_in` as the carry. Extended add (code 9) gives `ra_val + rb_val`. Extended subtract-from (code 10) gives `~ra_val + rb_val`. Add-to-zero (code 11) gives `ra_val + 0`. Subtract-from-zero (code 12) gives `~ra_val + 0`. Add-to-minus-one (code 13) gives `ra_val + 0xFFFFFFFF`. Subtract-from-minus-one (code 14) gives `~ra_val + 0xFFFFFFFF`.
- R6: Codes 2, 3, 4 and 7 to 14 assert `ca_we`, with `ca_out` equal to the carry out of bit 31. Codes 0, 1, 5 and 6 leave `ca_we` low.
- R7: On a register form (codes 5 to 14) with `oe_bit` set, `ov_we` is high. `ov_out` is 1 exactly when both summed operands have the same sign and the sum's sign differs from it. `so_out` is always `so_in` OR (`ov_we` AND `ov_out`), so the summary bit is never cleared.
- R8: `cr_we` is high on a register form with `rc_bit` set, and always on code 3. The field is {negative, positive, zero, `so_out`}, from bit 3 down to bit 0, and the result is read as a signed value.
- R9: Immediate forms (codes 0 to 4) ignore `oe_bit` and `rc_bit`. They never assert `ov_we`, and only code 3 asserts `cr_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_op | input | 4 | Operation code (0 to 14) |
| ra_val | input | 32 | First register value |
| ra_is_zero | input | 1 | First register field was zero |
| rb_val | input | 32 | Second register value |
| imm_val | input | 16 | Immediate field |
| ca_in | input | 1 | Stored carry bit |
| so_in | input | 1 | Stored summary-overflow bit |
| oe_bit | input | 1 | Overflow-enable bit of a register form |
| rc_bit | input | 1 | Record bit of a register form |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Sum |
| ca_we | output | 1 | Carry write enable |
| ca_out | output | 1 | New carry |
| ov_we | output | 1 | Overflow write enable |
| ov_out | output | 1 | New overflow |
| so_out | output | 1 | New summary overflow |
| cr_we | output | 1 | Condition field write enable |
| cr_field | output | 4 | Condition field |

## Verification
Every output of this stage is due exactly one clock edge after the cycle that presents an operation, since only one register stage lies between the inputs and the outputs. The driver applies each operation on a falling edge and pushes its expected outcome into a queue at that moment. The monitor wakes just after each rising edge, pops one entry per `out_valid` cycle, and compares it. On a cycle with no result, the monitor checks that no write enable is high. Idle gaps between operations therefore also show whether the one-cycle spacing holds.

// File: rtl/fxadd_pkg.sv
// Package: operation codes shared by the add/subtract stage and its checker.
// Assumes: the decoder maps each instruction onto one of these 4-bit codes.
package fxadd_pkg;
    typedef enum logic [3:0] {
        FX_ADDI     = 4'd0,
        FX_ADDIS    = 4'd1,
        FX_ADDIC    = 4'd2,
        FX_ADDIC_R  = 4'd3,
        FX_SUBFIC   = 4'd4,
        FX_ADD      = 4'd5,
        FX_SUBF     = 4'd6,
        FX_ADDC     = 4'd7,
        FX_SUBFC    = 4'd8,
        FX_ADDE     = 4'd9,
        FX_SUBFE    = 4'd10,
        FX_ADDZE    = 4'd11,
        FX_SUBFZE   = 4'd12,
        FX_ADDME    = 4'd13,
        FX_SUBFME   = 4'd14,
        FX_NONE     = 4'd15
    } fx_op_e;
endpackage

// File: rtl/fxadd_opsel.sv
// Module: fxadd_opsel
// Picks the two summands and the carry-in for each operation code, and
// reports which status updates the code may perform.
// Assumes: WIDTH > IMM_W. Code 15 yields a zero sum and requests nothing.
module fxadd_opsel
    import fxadd_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  fx_op_e             op,
    input  logic [WIDTH-1:0]   ra,
    input  logic               ra_zero,
    input  logic [WIDTH-1:0]   rb,
    input  logic [IMM_W-1:0]   imm,
    input  logic               ca_in,
    output logic [WIDTH-1:0]   src1,
    output logic [WIDTH-1:0]   src2,
    output logic               cin,
    output logic               ca_en,
    output logic               reg_form,
    output logic               rec_force
);
    localparam int EXT_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] simm;
    logic [WIDTH-1:0] simm_hi;
    logic [WIDTH-1:0] ra_or0;

    // Sign-extended, shifted and zero-substituted operand candidates.
    always_comb begin
        simm    = {{EXT_W{imm[IMM_W-1]}}, imm};
        simm_hi = simm << IMM_W;
        ra_or0  = ra_zero ? '0 : ra;
    end

    // Operand, carry-in and permission selection per code.
    always_comb begin
        src1      = '0;
        src2      = '0;
        cin       = 1'b0;
        ca_en     = 1'b0;
        reg_form  = 1'b0;
        rec_force = 1'b0;
        unique case (op)
            FX_ADDI:    begin src1 = ra_or0; src2 = simm; end
            FX_ADDIS:   begin src1 = ra_or0; src2 = simm_hi; end
            FX_ADDIC:   begin src1 = ra; src2 = simm; ca_en = 1'b1; end
            FX_ADDIC_R: begin src1 = ra; src2 = simm; ca_en = 1'b1; rec_force = 1'b1; end
            FX_SUBFIC:  begin src1 = ~ra; src2 = simm; cin = 1'b1; ca_en = 1'b1; end
            FX_ADD:     begin src1 = ra; src2 = rb; reg_form = 1'b1; end
            FX_SUBF:    begin src1 = ~ra; src2 = rb; cin = 1'b1; reg_form = 1'b1; end
            FX_ADDC:    begin src1 = ra; src2 = rb; ca_en = 1'b1; reg_form = 1'b1; end
            FX_SUBFC:   begin src1 = ~ra; src2 = rb; cin = 1'b1; ca_en = 1'b1; reg_form = 1'b1; end
            FX_ADDE:    begin src1 = ra; src2 = rb; cin = ca_in; ca_en = 1'b1; reg_form = 1'b1; end
            FX_SUBFE:   begin src1 = ~ra; src2 = rb; cin = ca_in; ca_en = 1'b1; reg_form = 1'b1; end
            FX_ADDZE:   begin src1 = ra; cin = ca_in; ca_en = 1'b1; reg_form = 1'b1; end
            FX_SUBFZE:  begin src1 = ~ra; cin = ca_in; ca_en = 1'b1; reg_form = 1'b1; end
            FX_ADDME:   begin src1 = ra; src2 = '1; cin = ca_in; ca_en = 1'b1; reg_form = 1'b1; end
            FX_SUBFME:  begin src1 = ~ra; src2 = '1; cin = ca_in; ca_en = 1'b1; reg_form = 1'b1; end
            default:    begin src1 = '0; end
        endcase
    end
endmodule

// File: rtl/fxadd_sum.sv
// Module: fxadd_sum
// One adder shared by all codes: sum, carry out of the top bit and
// two's-complement overflow of src1 + src2 + cin.
// Assumes: purely combinational, registered by the parent.
module fxadd_sum #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] src1,
    input  logic [WIDTH-1:0] src2,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    // Wide add that exposes the carry out.
    always_comb begin
        {cout, sum} = {1'b0, src1} + {1'b0, src2} + {{WIDTH{1'b0}}, cin};
        ovf = (src1[MSB] == src2[MSB]) && (sum[MSB] != src1[MSB]);
    end
endmodule

// File: rtl/fxadd_cond.sv
// Module: fxadd_cond
// Builds the 4-bit condition field {negative, positive, zero, summary}.
// Assumes: the sum is read as a signed value.
module fxadd_cond #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             so,
    output logic [3:0]       field
);
    logic is_zero;
    logic is_neg;

    // Sign and zero tests, then field packing.
    always_comb begin
        is_zero = (sum == '0);
        is_neg  = sum[WIDTH-1];
        field   = {is_neg, !is_neg && !is_zero, is_zero, so};
    end
endmodule

// File: rtl/fxadd_unit.sv
// Module: fxadd_unit (top)
// Single-cycle registered add/subtract stage. Selects operands, adds,
// decides which status targets are written, and registers everything.
// Assumes: synchronous active-low reset; status writes happen only for an
// accepted operation; the caller owns the status register itself.
module fxadd_unit
    import fxadd_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic [WIDTH-1:0] ra_val,
    input  logic             ra_is_zero,
    input  logic [WIDTH-1:0] rb_val,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             ca_in,
    input  logic             so_in,
    input  logic             oe_bit,
    input  logic             rc_bit,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             ca_we,
    output logic             ca_out,
    output logic             ov_we,
    output logic             ov_out,
    output logic             so_out,
    output logic             cr_we,
    output logic [3:0]       cr_field
);
    logic [WIDTH-1:0] s1, s2, sum;
    logic             cin, ca_en, reg_form, rec_force, cout, ovf;
    logic             ov_en, cr_en, so_next;
    logic [3:0]       field;

    fxadd_opsel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
        .op(fx_op_e'(in_op)), .ra(ra_val), .ra_zero(ra_is_zero), .rb(rb_val),
        .imm(imm_val), .ca_in(ca_in), .src1(s1), .src2(s2), .cin(cin),
        .ca_en(ca_en), .reg_form(reg_form), .rec_force(rec_force)
    );

    fxadd_sum #(.WIDTH(WIDTH)) u_sum (
        .src1(s1), .src2(s2), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
    );

    // Recording decisions gated by the form and the OE / Rc bits.
    always_comb begin
        ov_en   = reg_form && oe_bit;
        cr_en   = (reg_form && rc_bit) || rec_force;
        so_next = so_in || (ov_en && ovf);
    end

    fxadd_cond #(.WIDTH(WIDTH)) u_cond (
        .sum(sum), .so(so_next), .field(field)
    );

    // Output register: captures a result only on an accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ca_we     <= 1'b0;
            ca_out    <= 1'b0;
            ov_we     <= 1'b0;
            ov_out    <= 1'b0;
            so_out    <= 1'b0;
            cr_we     <= 1'b0;
            cr_field  <= '0;
        end else begin
            out_valid <= in_valid;
            ca_we     <= in_valid && ca_en;
            ov_we     <= in_valid && ov_en;
            cr_we     <= in_valid && cr_en;
            if (in_valid) begin
                result   <= sum;
                ca_out   <= cout;
                ov_out   <= ov_en && ovf;
                so_out   <= so_next;
                cr_field <= field;
            end
        end
    end
endmodule

// File: rtl/fxadd_unit_chk.sv
// Module: fxadd_unit_chk
// Temporal checks on the stage's ports, bound into every fxadd_unit.
// Assumes: synchronous active-low reset; properties are off during reset.
module fxadd_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       so_in,
    input logic       out_valid,
    input logic       ca_we,
    input logic       ov_we,
    input logic       ov_out,
    input logic       so_out,
    input logic       cr_we,
    input logic [3:0] cr_field
);
    // R1: one-cycle latency
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1: no writes on idle cycles
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(ca_we || ov_we || cr_we));
    // R7: summary bit is sticky
    assert_so_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && so_in) |=> so_out);
    // R7: an overflow sets the summary bit
    assert_ov_sets_so_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_we && ov_out) |-> so_out);
    // R8: exactly one of negative / positive / zero
    assert_cr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr_field[3:1]) == 1));
    // R8: summary copy in bit 0
    assert_cr_so_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (cr_field[0] == so_out));
endmodule

bind fxadd_unit fxadd_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .so_in(so_in),
    .out_valid(out_valid), .ca_we(ca_we), .ov_we(ov_we), .ov_out(ov_out),
    .so_out(so_out), .cr_we(cr_we), .cr_field(cr_field)
);

// File: tb/fxadd_unit_tb.sv
// Scoreboard bench: the driver queues expected outcomes, the monitor pops
// and compares them one edge later.
module fxadd_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] ra_val = '0, rb_val = '0;
    logic        ra_is_zero = 1'b0;
    logic [15:0] imm_val = '0;
    logic        ca_in = 1'b0, so_in = 1'b0, oe_bit = 1'b0, rc_bit = 1'b0;
    logic        out_valid, ca_we, ca_out, ov_we, ov_out, so_out, cr_we;
    logic [31:0] result;
    logic [3:0]  cr_field;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        ca_we, ca, ov_we, ov, so, cr_we;
        logic [3:0]  cr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    fxadd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .ra_val(ra_val), .ra_is_zero(ra_is_zero), .rb_val(rb_val),
        .imm_val(imm_val), .ca_in(ca_in), .so_in(so_in), .oe_bit(oe_bit),
        .rc_bit(rc_bit), .out_valid(out_valid), .result(result),
        .ca_we(ca_we), .ca_out(ca_out), .ov_we(ov_we), .ov_out(ov_out),
        .so_out(so_out), .cr_we(cr_we), .cr_field(cr_field)
    );

    // Reference outcome written from the requirements R2 to R9.
    function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                   input logic az, input logic [31:0] b,
                                   input logic [15:0] im, input logic c,
                                   input logic s, input logic oe, input logic rc,
                                   input string tag);
        exp_t e;
        logic [31:0] x, y, se;
        logic ci, regf;
        logic [32:0] w;
        logic ovf;
        se = {{16{im[15]}}, im};
        ci = 1'b0;
        x = a; y = b;
        case (op)
            4'd0: begin x = az ? 32'd0 : a; y = se; end
            4'd1: begin x = az ? 32'd0 : a; y = {im, 16'h0}; end
            4'd2, 4'd3: y = se;
            4'd4: begin x = ~a; y = se; ci = 1'b1; end
            4'd5, 4'd7: ;
            4'd6, 4'd8: begin x = ~a; ci = 1'b1; end
            4'd9: ci = c;
            4'd10: begin x = ~a; ci = c; end
            4'd11: begin y = 32'd0; ci = c; end
            4'd12: begin x = ~a; y = 32'd0; ci = c; end
            4'd13: begin y = 32'hFFFF_FFFF; ci = c; end
            default: begin x = ~a; y = 32'hFFFF_FFFF; ci = c; end
        endcase
        w = {1'b0, x} + {1'b0, y} + {32'd0, ci};
        regf = (op >= 4'd5);
        ovf = (x[31] == y[31]) && (w[31] != x[31]);
        e.res   = w[31:0];
        e.ca_we = !(op == 4'd0 || op == 4'd1 || op == 4'd5 || op == 4'd6);
        e.ca    = w[32];
        e.ov_we = regf && oe;
        e.ov    = e.ov_we && ovf;
        e.so    = s | e.ov;
        e.cr_we = (regf && rc) || op == 4'd3;
        e.cr    = {w[31], !w[31] && w[31:0] != 0, w[31:0] == 0, e.so};
        e.tag   = tag;
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic az,
                         input logic [31:0] b, input logic [15:0] im, input logic c,
                         input logic s, input logic oe, input logic rc, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; ra_val = a; ra_is_zero = az; rb_val = b;
        imm_val = im; ca_in = c; so_in = s; oe_bit = oe; rc_bit = rc;
        sb.push_back(model(op, a, az, b, im, c, s, oe, rc, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        oe_bit = 1'b1; rc_bit = 1'b1;
    endtask

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd2 || op == 4'd3) return (op == 4'd1) ? "R3" : "R2";
        if (op <= 4'd8) return "R4";
        return "R5";
    endfunction

    // Monitor: compare one queued item per result cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !done) begin
                if (out_valid) begin
                    n_checks++;
                    if (sb.size() == 0) begin
                        n_fail++;
                        $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (result !== e.res || ca_we !== e.ca_we || ov_we !== e.ov_we
                            || cr_we !== e.cr_we || so_out !== e.so
                            || (e.ca_we && ca_out !== e.ca) || (e.ov_we && ov_out !== e.ov)
                            || (e.cr_we && cr_field !== e.cr)) begin
                            n_fail++;
                            $display("FAIL %s: actual res=%h caw=%b ca=%b ovw=%b ov=%b so=%b crw=%b cr=%b expected res=%h caw=%b ca=%b ovw=%b ov=%b so=%b crw=%b cr=%b",
                                     e.tag, result, ca_we, ca_out, ov_we, ov_out, so_out, cr_we, cr_field,
                                     e.res, e.ca_we, e.ca, e.ov_we, e.ov, e.so, e.cr_we, e.cr);
                        end
                    end
                end else begin
                    n_checks++;
                    if (ca_we || ov_we || cr_we || sb.size() != 0) begin
                        n_fail++;
                        $display("FAIL R1: idle cycle actual we=%b%b%b pending=%0d expected we=000 pending=0",
                                 ca_we, ov_we, cr_we, sb.size());
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(1_000_000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (out_valid || result != 0 || ca_we || ov_we || cr_we || so_out || cr_field != 0) begin
            n_fail++;
            $display("FAIL R1: reset state actual v=%b res=%h expected all zero", out_valid, result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R2: immediate add, with and without the zero-field substitution
        drive(4'd0, 32'd5, 1'b0, 32'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        drive(4'd0, 32'd99, 1'b1, 32'd0, 16'h0007, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        drive(4'd2, 32'd99, 1'b1, 32'd0, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        // R3: shifted immediate
        drive(4'd1, 32'd1, 1'b1, 32'd0, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        drive(4'd1, 32'd1, 1'b0, 32'd0, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        idle();
        // R4: register add and subtract-from
        drive(4'd6, 32'd3, 1'b0, 32'd10, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        drive(4'd4, 32'd0, 1'b0, 32'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        // R6: carry out of bit 31 on a carrying add, zero result recorded
        drive(4'd7, 32'hFFFF_FFFF, 1'b0, 32'd1, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        // R7/R8: signed overflow, sticky summary, negative field
        drive(4'd5, 32'h7FFF_FFFF, 1'b0, 32'd1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        drive(4'd5, 32'd1, 1'b0, 32'd1, 16'h0, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
        drive(4'd5, 32'd1, 1'b0, 32'd1, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        // R5: extended forms with stored carry
        drive(4'd9, 32'd1, 1'b0, 32'd2, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        drive(4'd13, 32'd0, 1'b0, 32'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        drive(4'd13, 32'd0, 1'b0, 32'd0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        drive(4'd11, 32'hFFFF_FFFF, 1'b0, 32'd0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        drive(4'd12, 32'd5, 1'b0, 32'd0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        drive(4'd14, 32'd5, 1'b0, 32'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        drive(4'd10, 32'd5, 1'b0, 32'd3, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        idle();
        // R9: immediate forms ignore OE and Rc; code 3 always records
        drive(4'd0, 32'h7FFF_FFFF, 1'b0, 32'd0, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        drive(4'd2, 32'h7FFF_FFFF, 1'b0, 32'd0, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        drive(4'd3, 32'hFFFF_FFFF, 1'b0, 32'd0, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        idle();
        idle();
        // Mixed patterns, some with gaps.
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 14));
            drive(op, $urandom, 1'($urandom), $urandom, 16'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), tag_of(op));
            if (($urandom % 5) == 0) idle();
        end
        idle();
        idle();
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule